// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is the target side of a two-wire serial memory. SCL and SDA arrive as open-drain levels. They are registered against the system clock, and the block finds bus edges and START and STOP conditions from those samples. It holds a 128-byte array. A host selects the device with a type code and then writes one byte at a chosen address. It can also read back from an address it sets, or from wherever the internal pointer last stopped.

A committed write starts an internal programming interval whose length is a parameter counted in system clocks. During that interval the device ignores its select byte, so the host learns that programming has finished by repeating START plus select until it sees an acknowledge. A write-control input can block array updates without changing the bus handshake.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: During and right after reset the device does not pull SDA low (`sda_oe` = 0).
- R2: Decoding begins only after a START (SDA falling while SCL is high). The first byte is taken MSB first. The device acknowledges (drives SDA low in the 9th clock) only when the upper four bits equal 1010; bit 0 selects read (1) or write (0).
- R3: Select bits 3 to 1 are ignored when matching.
- R4: A write select, then an address byte, then a data byte are each acknowledged. The following STOP stores the data at the address's low 7 bits.
- R5: While `wc_n` is low at the data byte, every byte is still acknowledged, the array stays unchanged and no programming interval starts.
- R6: After a committing STOP, select bytes are not acknowledged for WR_CYCLES clocks. After that they are acknowledged again.
- R7: Write select, address, repeated START and read select return the addressed byte MSB first.
- R8: The pointer advances by one after each byte read or written and wraps from 127 to 0. A read select without an address continues from the pointer.
- R9: When the host does not acknowledge a read byte, the device stops driving SDA until the next START.
- R10: STOP returns the interface to idle from any state. A START in the middle of a byte restarts select decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock level from the bus |
| sda_i | input | 1 | Serial data level from the bus |
| wc_n | input | 1 | Write enable; low blocks array updates |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench builds the block with WR_CYCLES = 400 and the default 7-bit address. A 400-clock programming interval outlasts a single select attempt, so acknowledge polling sees at least one rejected select before the accepted one, and the run stays short. The full 7-bit address lets a sequential read cross from 127 back to 0 and then continue with a current-address read.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int ADDR_W    = 7,
  parameter int WR_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wc_n,
  output logic sda_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW    = $clog2(WR_CYCLES + 1);
  localparam logic [2:0] S_IDLE = 3'd0, S_SEL = 3'd1, S_ADDR = 3'd2,
                         S_WDAT = 3'd3, S_RDAT = 3'd4;

  logic scl_r, scl_p, sda_r, sda_p;
  logic [2:0] st, nxt;
  logic [3:0] cnt;
  logic ackph, nack, pend;
  logic [7:0] sr, tx, pend_data;
  logic [ADDR_W-1:0] ptr, pend_addr;
  logic [TW-1:0] tmr;
  logic [7:0] mem [DEPTH];

  logic start_det, stop_det, scl_rise, scl_fall, busy, commit;
  assign start_det = scl_r & scl_p & sda_p & ~sda_r;
  assign stop_det  = scl_r & scl_p & ~sda_p & sda_r;
  assign scl_rise  = scl_r & ~scl_p;
  assign scl_fall  = ~scl_r & scl_p;
  assign busy      = tmr != '0;
  assign commit    = stop_det & pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_r <= 1'b1; scl_p <= 1'b1; sda_r <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_r <= scl_i; scl_p <= scl_r; sda_r <= sda_i; sda_p <= sda_r;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[pend_addr] <= pend_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      tmr <= '0;
    else if (commit) tmr <= TW'(WR_CYCLES);
    else if (busy)   tmr <= tmr - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE; cnt <= '0; ackph <= 1'b0; nack <= 1'b0;
      sr <= '0; tx <= '0; ptr <= '0; pend_addr <= '0; pend_data <= '0;
      pend <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE; ackph <= 1'b0; sda_oe <= 1'b0; pend <= 1'b0;
    end else if (start_det) begin
      st <= S_SEL; cnt <= '0; ackph <= 1'b0; sda_oe <= 1'b0; pend <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (ackph) nack <= sda_r;
        else begin
          sr  <= {sr[6:0], sda_r};
          cnt <= cnt + 4'd1;
        end
      end else if (scl_fall) begin
        if (ackph) begin
          ackph <= 1'b0; cnt <= '0; sda_oe <= 1'b0;
          if (st == S_RDAT && nack) st <= S_IDLE;
          else begin
            st <= nxt;
            if (nxt == S_RDAT) begin
              tx     <= mem[ptr];
              sda_oe <= ~mem[ptr][7];
            end
          end
        end else if (cnt == 4'd8) begin
          ackph <= 1'b1; nack <= 1'b0;
          case (st)
            S_SEL: begin
              if (sr[7:4] == 4'b1010 && !busy) begin
                sda_oe <= 1'b1;
                nxt    <= sr[0] ? S_RDAT : S_ADDR;
              end else begin
                sda_oe <= 1'b0;
                nxt    <= S_IDLE;
              end
            end
            S_ADDR: begin
              sda_oe <= 1'b1; ptr <= sr[ADDR_W-1:0]; nxt <= S_WDAT;
            end
            S_WDAT: begin
              sda_oe <= 1'b1; ptr <= ptr + 1'b1; nxt <= S_WDAT;
              if (wc_n) begin
                pend <= 1'b1; pend_addr <= ptr; pend_data <= sr;
              end
            end
            S_RDAT: begin
              sda_oe <= 1'b0; ptr <= ptr + 1'b1; nxt <= S_RDAT;
            end
            default: nxt <= S_IDLE;
          endcase
        end else if (st == S_RDAT && cnt != 4'd0) begin
          sda_oe <= ~tx[3'd7 - cnt[2:0]];
        end
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] st,
  input logic [3:0] cnt,
  input logic       start_det,
  input logic       stop_det,
  input logic       busy,
  input logic       sda_oe
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !sda_oe)
    else $error("R1 sda driven after reset");

  p_start_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == 3'd1 && cnt == 4'd0))
    else $error("R2 START did not restart select decoding");

  p_busy_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == 3'd1) |-> !sda_oe)
    else $error("R6 select acknowledged while programming");

  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == 3'd0 && !sda_oe))
    else $error("R10 STOP did not return to idle");
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .cnt(cnt), .start_det(start_det),
  .stop_det(stop_det), .busy(busy), .sda_oe(sda_oe)
);

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;
  localparam int CLK_NS = 10;
  localparam int HALF   = 8;
  localparam int WRC    = 400;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_h = 1'b1, wc_n = 1'b1;
  logic sda_oe;
  logic sda_bus;
  assign sda_bus = sda_h & ~sda_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  i2c_eeprom_slave #(.ADDR_W(7), .WR_CYCLES(WRC)) u_i2c_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .wc_n(wc_n), .sda_oe(sda_oe));

  // {wc_n, address, data, expected readback}
  localparam logic [24:0] VEC [6] = '{
    {1'b1, 8'h05, 8'h5A, 8'h5A},
    {1'b1, 8'h7F, 8'hC3, 8'hC3},
    {1'b0, 8'h05, 8'h11, 8'h5A},
    {1'b1, 8'h00, 8'h00, 8'h00},
    {1'b1, 8'h05, 8'hE7, 8'hE7},
    {1'b0, 8'h7F, 8'h00, 8'hC3}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i_start();
    sda_h = 1'b1; tick(HALF); scl = 1'b1; tick(HALF);
    sda_h = 1'b0; tick(HALF); scl = 1'b0; tick(HALF);
  endtask

  task automatic i_stop();
    sda_h = 1'b0; tick(HALF); scl = 1'b1; tick(HALF);
    sda_h = 1'b1; tick(HALF);
  endtask

  task automatic clk_bit(input bit b);
    sda_h = b; tick(HALF); scl = 1'b1; tick(HALF); scl = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    sda_h = 1'b1; tick(HALF); scl = 1'b1; tick(HALF/2);
    ack = !sda_bus; tick(HALF/2); scl = 1'b0;
  endtask

  task automatic recv(output logic [7:0] b, input bit host_ack);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HALF); scl = 1'b1; tick(HALF/2); b[i] = sda_bus; tick(HALF/2); scl = 1'b0;
    end
    sda_h = !host_ack; tick(HALF); scl = 1'b1; tick(HALF); scl = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] a, input logic [7:0] d, output int nacks);
    bit k;
    nacks = 0;
    i_start();
    send(8'hA0, k); if (!k) nacks++;
    send(a, k);     if (!k) nacks++;
    send(d, k);     if (!k) nacks++;
    i_stop();
  endtask

  task automatic poll(output int tries);
    bit k;
    tries = 0;
    do begin
      tries++;
      i_start(); send(8'hA0, k); i_stop();
    end while (!k && tries < 40);
  endtask

  task automatic read_at(input logic [7:0] a, output logic [7:0] d);
    bit k;
    i_start(); send(8'hA0, k); send(a, k);
    i_start(); send(8'hA1, k); recv(d, 1'b0); i_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    bit k;
    logic [7:0] d;
    tick(5);
    chk(sda_oe == 1'b0, "R1 oe in reset", sda_oe, 0);
    rst_n = 1'b1; tick(3);
    chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);

    foreach (VEC[i]) begin
      wc_n = VEC[i][24];
      write_byte(VEC[i][23:16], VEC[i][15:8], n);
      chk(n == 0, VEC[i][24] ? "R4 write acks" : "R5 acks while blocked", n, 0);
      poll(n);
      if (VEC[i][24]) chk(n > 1 && n < 40, "R6 polling rejects then accepts", n, 2);
      else            chk(n == 1, "R5 no programming interval", n, 1);
      wc_n = 1'b1;
      read_at(VEC[i][23:16], d);
      chk(d == VEC[i][7:0], "R7 random read value", d, VEC[i][7:0]);
    end

    // R2: wrong type code gets no acknowledge
    i_start(); send(8'hB0, k); i_stop();
    chk(!k, "R2 wrong type code", k, 0);

    // R3: don't-care select bits
    i_start(); send(8'hAE, k);
    chk(k, "R3 write select 1010_111", k, 1);
    send(8'h05, k);
    i_start(); send(8'hA3, k);
    chk(k, "R3 read select 1010_001", k, 1);
    recv(d, 1'b0); i_stop();
    chk(d == 8'hE7, "R3 read via don't-care select", d, 8'hE7);

    // R8: sequential read with wrap, then current-address read
    write_byte(8'h7E, 8'h99, n); poll(n);
    write_byte(8'h01, 8'h42, n); poll(n);
    i_start(); send(8'hA0, k); send(8'h7E, k);
    i_start(); send(8'hA1, k);
    recv(d, 1'b1); chk(d == 8'h99, "R8 first byte", d, 8'h99);
    recv(d, 1'b1); chk(d == 8'hC3, "R8 second byte", d, 8'hC3);
    recv(d, 1'b0); chk(d == 8'h00, "R8 wrap to 0", d, 8'h00);
    // R9: after host NACK the device stays off the bus
    recv(d, 1'b0); chk(d == 8'hFF, "R9 silent after nack", d, 8'hFF);
    i_stop();
    i_start(); send(8'hA1, k); recv(d, 1'b0); i_stop();
    chk(d == 8'h42, "R8 current-address read", d, 8'h42);

    // R10: STOP mid-transaction, then bytes without START are ignored
    i_start(); send(8'hA0, k); send(8'h05, k); i_stop();
    sda_h = 1'b1; tick(HALF); scl = 1'b0; tick(HALF);
    send(8'hA0, k); sda_h = 1'b1; tick(HALF);
    chk(!k, "R10 idle after STOP", k, 0);
    i_stop();
    // R10: START inside a byte restarts select decoding
    i_start(); clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
    i_start(); send(8'hA1, k);
    chk(k, "R10 select after mid-byte START", k, 1);
    recv(d, 1'b0); i_stop();
    chk(d == 8'hE7, "R10 read after restart", d, 8'hE7);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule